// File: doc/BRIEF.md
# Timestamp-Gated Transmit Scheduler

This block sits at the head of a transmit queue. Each packet in the queue is a fixed 512-byte frame of 32-bit words: first a header word, then a timestamp word, then a body of payload and padding. The block keeps its own free-running sample-time counter, which advances by one on every sample-clock enable. It compares each timestamp with that counter. A packet whose time lies ahead is held until its slot comes. A packet with the all-ones "immediately" code is released at once. A packet whose slot has already passed is thrown away as a whole. Released payload words go to the converter-side sample port, one word per sample slot.

The block also tracks bursts. A start-of-burst header opens a burst, and the end-of-burst header closes it once its payload has gone out. A sample slot that finds no data while a burst is open is counted as an underrun. The same empty slot outside a burst is normal idle time, and the output then carries zero. Dropped packets and underruns each give a one-cycle pulse and also set a sticky flag. The return-path packetizer clears these flags when it has reported them.

Top module: `tx_time_gate`

## Requirements
- R1: After a synchronous active-low reset, q_ready is 1, dac_valid is 0, dac_data is 0, now_time is 0, and both pulses and both sticky flags are 0.
- R2: now_time increases by exactly one, modulo 2^32, at each clock edge where smp_en is high, and holds its value otherwise.
- R3: A timed packet sends its first payload word in the sample slot whose time equals the timestamp. The word appears on dac_data with dac_valid high in the cycle after that enable edge. The remaining words follow in order, one per slot.
- R4: A timestamp of 0xFFFFFFFF releases the packet with no wait and no late test. Its payload words go out in consecutive slots.
- R5: When the timestamp word is accepted, the packet counts as late if (now_time + smp_en − timestamp), taken as a signed 32-bit value, is greater than zero. This comparison is wraparound-safe. A late packet is consumed in full (all 128 words) and sends no sample. drop_pulse is high for one cycle and drop_flag is set.
- R6: Header bits 8:0 hold the payload length in bytes. floor(length/4) words are sent, with a cap of 126. Payload bytes that do not fill a whole word are not sent. The other body words, up to 126, are consumed and never sent. Header bit 28 is start-of-burst and bit 27 is end-of-burst. All other header bits are ignored.
- R7: A burst opens when a start-of-burst packet is released. It stays open until an end-of-burst packet has finished its payload or has been dropped. While the burst is open, a sample slot without a payload word pulses urun_pulse and sets urun_flag. Slots spent waiting for a future timestamp are exempt. A slot with words left in the current packet and no word offered is also an underrun.
- R8: A sample slot with no payload word sets dac_data to 0. Empty slots outside a burst raise no underrun.
- R9: Each sticky flag stays set until a cycle with flag_clr high clears it. A new event in the same cycle as the clear wins, and each pulse is matched by its flag in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_en | input | 1 | Sample-clock enable; one sample slot per high cycle |
| q_data | input | 32 | Word at the head of the transmit queue |
| q_valid | input | 1 | q_data holds a word |
| q_ready | output | 1 | The block takes q_data at this edge |
| dac_data | output | 32 | Sample for the converter, zero on empty slots |
| dac_valid | output | 1 | dac_data carries a payload word |
| now_time | output | 32 | Free-running sample-time counter |
| drop_pulse | output | 1 | One-cycle pulse: a late packet was discarded |
| urun_pulse | output | 1 | One-cycle pulse: empty slot inside a burst |
| drop_flag | output | 1 | Sticky drop indication |
| urun_flag | output | 1 | Sticky underrun indication |
| flag_clr | input | 1 | Clears both sticky flags |

## Verification
Each payload sample shows up one cycle after the enable edge that takes it. now_time has already advanced at that point, so the bench records each sample's slot as now_time minus one and compares that slot with the timestamp. drop_pulse and urun_pulse, together with their flags, rise one cycle after the timestamp acceptance or the empty slot that causes them. All outputs are sampled on the falling edge, and results are only judged after the queue has drained and a settling window has passed. The bench sweeps payload lengths exhaustively from 0 to 40 bytes and also covers the 504 and 511 limits.

// File: rtl/tgs_pkg.sv
// Shared types and frame-field positions for the transmit time gate.
// Assumes 32-bit queue words; header bit positions are fixed by the frame.
package tgs_pkg;

    typedef enum logic [2:0] {
        ST_HDR   = 3'd0,
        ST_STAMP = 3'd1,
        ST_WAIT  = 3'd2,
        ST_SEND  = 3'd3,
        ST_SKIP  = 3'd4
    } st_e;

    localparam int SOB_BIT  = 28;
    localparam int EOB_BIT  = 27;
    localparam int FLG_DROP = 0;
    localparam int FLG_URUN = 1;
    localparam int NFLAG    = 2;

endpackage

// File: rtl/tgs_timebase.sv
// Free-running sample-time counter. It advances once per sample enable
// and wraps modulo 2^TW. Assumes smp_en is synchronous to clk.
module tgs_timebase #(
    parameter int TW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_en,
    output logic [TW-1:0] now
);

    // count sample slots
    always_ff @(posedge clk) begin
        if (!rst_n)
            now <= '0;
        else if (smp_en)
            now <= now + 1'b1;
    end

endmodule

// File: rtl/tgs_late_cmp.sv
// Classifies a timestamp word. The all-ones code means send at once.
// Otherwise the packet is late when the next usable slot time lies
// past the stamp, using a signed wraparound-safe difference.
module tgs_late_cmp #(
    parameter int TW = 32
) (
    input  logic [TW-1:0] now,
    input  logic          smp_en,
    input  logic [TW-1:0] stamp,
    output logic          immed,
    output logic          late
);

    logic [TW-1:0] next_slot;
    logic [TW-1:0] diff;

    // signed slot difference; slot now is consumed this cycle if smp_en
    always_comb begin
        next_slot = now + TW'(smp_en);
        diff      = next_slot - stamp;
        immed     = &stamp;
        late      = !diff[TW-1] && (diff != '0);
    end

endmodule

// File: rtl/tgs_flag.sv
// One status bit: registered pulse plus sticky flag. A new event wins
// over a clear arriving in the same cycle.
module tgs_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic clr,
    output logic pulse,
    output logic flag
);

    // pulse follows the event by one edge; flag accumulates it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse <= 1'b0;
            flag  <= 1'b0;
        end else begin
            pulse <= evt;
            flag  <= evt | (flag & ~clr);
        end
    end

endmodule

// File: rtl/tgs_ctrl.sv
// Packet sequencer. It reads the header and the timestamp, waits for the
// slot, sends the payload one word per sample slot, then skips the padding.
// Late packets are skipped whole. It also tracks the open-burst state and
// raises the drop and underrun events. Assumes fixed-size frames.
module tgs_ctrl
    import tgs_pkg::*;
#(
    parameter int TW        = 32,
    parameter int PKT_BYTES = 512,
    parameter int LEN_W     = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_en,
    input  logic [TW-1:0] q_data,
    input  logic          q_valid,
    input  logic [TW-1:0] now,
    input  logic          stamp_immed,
    input  logic          stamp_late,
    output logic          q_ready,
    output logic [TW-1:0] dac_data,
    output logic          dac_valid,
    output logic          drop_evt,
    output logic          urun_evt
);

    localparam int WORD_BYTES = TW / 8;
    localparam int SHIFT      = $clog2(WORD_BYTES);
    localparam int PKT_WORDS  = PKT_BYTES / WORD_BYTES;
    localparam int BODY_WORDS = PKT_WORDS - 2;
    localparam int IDX_W      = $clog2(BODY_WORDS + 1);

    st_e              st_q;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] pay_q;
    logic [IDX_W-1:0] pay_next;
    logic [TW-1:0]    ts_q;
    logic             sob_q;
    logic             eob_q;
    logic             in_burst_q;
    logic             slot_hit;
    logic             sending;
    logic             words_left;
    logic             emit;
    logic             take;
    logic [LEN_W-1:0] len_words;

    // payload word count from the header length, capped at the body size
    always_comb begin
        len_words = q_data[LEN_W-1:0] >> SHIFT;
        if (len_words > LEN_W'(BODY_WORDS))
            pay_next = IDX_W'(BODY_WORDS);
        else
            pay_next = IDX_W'(len_words);
    end

    // slot match, send window and word emission for this cycle
    always_comb begin
        slot_hit   = (st_q == ST_WAIT) && (now == ts_q);
        sending    = (st_q == ST_SEND) || slot_hit;
        words_left = idx_q < pay_q;
        emit       = sending && words_left && smp_en && q_valid;
    end

    // queue handshake: free in header, stamp and skip; slot-paced in send
    always_comb begin
        case (st_q)
            ST_HDR, ST_STAMP, ST_SKIP: q_ready = 1'b1;
            ST_WAIT, ST_SEND:          q_ready = sending && words_left && smp_en;
            default:                   q_ready = 1'b0;
        endcase
        take = q_valid && q_ready;
    end

    // status events for the flag units
    always_comb begin
        drop_evt = (st_q == ST_STAMP) && take && !stamp_immed && stamp_late;
        urun_evt = smp_en && !emit &&
                   ((sending && words_left) || (in_burst_q && st_q != ST_WAIT));
    end

    // packet sequencing, word index and burst tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= ST_HDR;
            idx_q      <= '0;
            pay_q      <= '0;
            ts_q       <= '0;
            sob_q      <= 1'b0;
            eob_q      <= 1'b0;
            in_burst_q <= 1'b0;
        end else begin
            case (st_q)
                ST_HDR: begin
                    if (take) begin
                        sob_q <= q_data[SOB_BIT];
                        eob_q <= q_data[EOB_BIT];
                        pay_q <= pay_next;
                        st_q  <= ST_STAMP;
                    end
                end
                ST_STAMP: begin
                    if (take) begin
                        ts_q  <= q_data;
                        idx_q <= '0;
                        if (stamp_immed) begin
                            st_q <= ST_SEND;
                            if (sob_q)
                                in_burst_q <= 1'b1;
                        end else if (stamp_late) begin
                            st_q <= ST_SKIP;
                            if (eob_q)
                                in_burst_q <= 1'b0;
                        end else begin
                            st_q <= ST_WAIT;
                        end
                    end
                end
                ST_WAIT: begin
                    if (slot_hit) begin
                        st_q <= ST_SEND;
                        if (sob_q)
                            in_burst_q <= 1'b1;
                        if (emit)
                            idx_q <= idx_q + 1'b1;
                    end
                end
                ST_SEND: begin
                    if (emit) begin
                        idx_q <= idx_q + 1'b1;
                    end else if (!words_left) begin
                        st_q <= (idx_q == IDX_W'(BODY_WORDS)) ? ST_HDR : ST_SKIP;
                        if (eob_q)
                            in_burst_q <= 1'b0;
                    end
                end
                ST_SKIP: begin
                    if (take) begin
                        idx_q <= idx_q + 1'b1;
                        if (idx_q == IDX_W'(BODY_WORDS - 1))
                            st_q <= ST_HDR;
                    end
                end
                default: st_q <= ST_HDR;
            endcase
        end
    end

    // converter port: sample on an emitting slot, zero on an empty slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dac_data  <= '0;
            dac_valid <= 1'b0;
        end else if (smp_en) begin
            dac_valid <= emit;
            dac_data  <= emit ? q_data : '0;
        end else begin
            dac_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/tx_time_gate.sv
// Top of the timestamp-gated transmit scheduler. Joins the time base,
// the stamp classifier, the packet sequencer and the two status flags.
// Assumes the queue offers whole fixed-size frames, header word first.
module tx_time_gate
    import tgs_pkg::*;
#(
    parameter int TW        = 32,
    parameter int PKT_BYTES = 512,
    parameter int LEN_W     = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_en,
    input  logic [TW-1:0] q_data,
    input  logic          q_valid,
    output logic          q_ready,
    output logic [TW-1:0] dac_data,
    output logic          dac_valid,
    output logic [TW-1:0] now_time,
    output logic          drop_pulse,
    output logic          urun_pulse,
    output logic          drop_flag,
    output logic          urun_flag,
    input  logic          flag_clr
);

    logic             stamp_immed;
    logic             stamp_late;
    logic             drop_evt;
    logic             urun_evt;
    logic [NFLAG-1:0] evt_v;
    logic [NFLAG-1:0] pls_v;
    logic [NFLAG-1:0] flg_v;

    tgs_timebase #(.TW(TW)) u_time (
        .clk    (clk),
        .rst_n  (rst_n),
        .smp_en (smp_en),
        .now    (now_time)
    );

    tgs_late_cmp #(.TW(TW)) u_cmp (
        .now    (now_time),
        .smp_en (smp_en),
        .stamp  (q_data),
        .immed  (stamp_immed),
        .late   (stamp_late)
    );

    tgs_ctrl #(.TW(TW), .PKT_BYTES(PKT_BYTES), .LEN_W(LEN_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .smp_en      (smp_en),
        .q_data      (q_data),
        .q_valid     (q_valid),
        .now         (now_time),
        .stamp_immed (stamp_immed),
        .stamp_late  (stamp_late),
        .q_ready     (q_ready),
        .dac_data    (dac_data),
        .dac_valid   (dac_valid),
        .drop_evt    (drop_evt),
        .urun_evt    (urun_evt)
    );

    // route events into the flag units by index
    always_comb begin
        evt_v           = '0;
        evt_v[FLG_DROP] = drop_evt;
        evt_v[FLG_URUN] = urun_evt;
    end

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        tgs_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .evt   (evt_v[g]),
            .clr   (flag_clr),
            .pulse (pls_v[g]),
            .flag  (flg_v[g])
        );
    end

    assign drop_pulse = pls_v[FLG_DROP];
    assign urun_pulse = pls_v[FLG_URUN];
    assign drop_flag  = flg_v[FLG_DROP];
    assign urun_flag  = flg_v[FLG_URUN];

endmodule

// File: rtl/tgs_chk.sv
// Port-level checker for the transmit time gate, bound to the top.
module tgs_chk #(
    parameter int TW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          smp_en,
    input logic [TW-1:0] now_time,
    input logic [TW-1:0] dac_data,
    input logic          dac_valid,
    input logic          drop_pulse,
    input logic          drop_flag,
    input logic          urun_pulse,
    input logic          urun_flag,
    input logic          flag_clr
);

    // R2
    time_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_en |=> now_time == $past(now_time) + 1'b1);

    // R2
    time_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_en |=> $stable(now_time));

    // R3
    dac_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dac_valid |-> $past(smp_en));

    // R8
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(smp_en) && !dac_valid) |-> dac_data == '0);

    // R5
    drop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop_pulse |-> !dac_valid);

    // R9
    drop_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop_pulse |-> drop_flag);

    // R9
    urun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        urun_pulse |-> urun_flag);

    // R9
    drop_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr |=> drop_flag == drop_pulse);

    // R9
    urun_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr |=> urun_flag == urun_pulse);

endmodule

bind tx_time_gate tgs_chk #(.TW(TW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_en     (smp_en),
    .now_time   (now_time),
    .dac_data   (dac_data),
    .dac_valid  (dac_valid),
    .drop_pulse (drop_pulse),
    .drop_flag  (drop_flag),
    .urun_pulse (urun_pulse),
    .urun_flag  (urun_flag),
    .flag_clr   (flag_clr)
);

// File: tb/sim_tx_time_gate.sv
`timescale 1ns/1ps
module sim_tx_time_gate;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_en = 1'b0;
    logic [31:0] q_data = '0;
    logic        q_valid = 1'b0;
    logic        q_ready;
    logic [31:0] dac_data;
    logic        dac_valid;
    logic [31:0] now_time;
    logic        drop_pulse, urun_pulse, drop_flag, urun_flag;
    logic        flag_clr = 1'b0;

    int n_chk = 0, n_fail = 0;
    int urun_cnt = 0, drop_cnt = 0, time_err = 0, smp_seen = 0;
    bit run = 1'b0;
    logic [31:0] wq[$];
    logic [31:0] s_data[$];
    logic [31:0] s_slot[$];

    always #2.5 clk = ~clk;

    tx_time_gate u0 (
        .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .q_data(q_data),
        .q_valid(q_valid), .q_ready(q_ready), .dac_data(dac_data),
        .dac_valid(dac_valid), .now_time(now_time), .drop_pulse(drop_pulse),
        .urun_pulse(urun_pulse), .drop_flag(drop_flag), .urun_flag(urun_flag),
        .flag_clr(flag_clr)
    );

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pl(input int pid, input int i);
        return 32'h5A00_0000 | (32'(pid) << 12) | 32'(i);
    endfunction

    // header: bit 28 start, bit 27 end, bits 8:0 length; channel bits as noise
    task automatic push_pkt(input bit sob, input bit eob, input int len,
                            input logic [31:0] ts, input int pid);
        int nw;
        nw = len / 4;
        wq.push_back((32'(sob) << 28) | (32'(eob) << 27) | 32'h0005_1400 | 32'(len));
        wq.push_back(ts);
        for (int i = 0; i < 126; i++)
            wq.push_back(i < nw ? pl(pid, i) : (32'hDEAD_0000 | 32'(i)));
    endtask

    task automatic settle(input int n);
        wait (wq.size() == 0);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic clear_samples();
        s_data.delete();
        s_slot.delete();
    endtask

    // compare captured samples with one packet's expected words
    task automatic expect_pkt(input string req, input int pid, input int nw,
                              input bit chk_slot, input logic [31:0] ts);
        bit ok;
        chk(s_data.size() == nw, {req, " sample count"}, 32'(s_data.size()), 32'(nw));
        ok = (s_data.size() == nw);
        for (int i = 0; i < s_data.size() && ok; i++) begin
            if (s_data[i] != pl(pid, i)) ok = 0;
            if (i > 0 && s_slot[i] != s_slot[i-1] + 1) ok = 0;
        end
        chk(ok, {req, " data and slot order"}, 32'(ok), 32'd1);
        if (chk_slot && s_slot.size() > 0)
            chk(s_slot[0] == ts, {req, " first slot time"}, s_slot[0], ts);
    endtask

    // queue driver, sample enable and output monitor
    initial begin
        int per_cnt;
        bit hs;
        per_cnt = 0;
        wait (run);
        forever begin
            @(negedge clk);
            hs = q_valid && q_ready;
            if (now_time != 32'(smp_seen)) time_err++;
            if (smp_en) smp_seen++;
            if (dac_valid) begin
                s_data.push_back(dac_data);
                s_slot.push_back(now_time - 1);
            end
            if (urun_pulse) urun_cnt++;
            if (drop_pulse) drop_cnt++;
            @(posedge clk);
            #1;
            if (hs) void'(wq.pop_front());
            q_valid = (wq.size() > 0);
            q_data  = (wq.size() > 0) ? wq[0] : 32'h0;
            per_cnt = (per_cnt == 3) ? 0 : per_cnt + 1;
            smp_en  = (per_cnt == 3);
        end
    end

    // watchdog
    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        logic [31:0] ts;
        int u0c, d0c, len, expw;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(q_ready == 1'b1, "R1 q_ready", 32'(q_ready), 32'd1);
        chk(dac_valid == 1'b0 && dac_data == 0, "R1 dac idle", dac_data, 32'd0);
        chk(now_time == 0, "R1 now_time", now_time, 32'd0);
        chk({drop_pulse, urun_pulse, drop_flag, urun_flag} == 4'b0, "R1 status",
            32'({drop_pulse, urun_pulse, drop_flag, urun_flag}), 32'd0);
        run = 1'b1;
        repeat (10) @(posedge clk);
        #1;

        // R3 timed packet, start and end of burst, 16 bytes
        clear_samples();
        ts = now_time + 32'd20;
        push_pkt(1, 1, 16, ts, 1);
        settle(40);
        expect_pkt("R3", 1, 4, 1, ts);

        // R4 immediate packet; R6 length 10 truncates to 2 words
        clear_samples();
        push_pkt(0, 1, 10, 32'hFFFF_FFFF, 2);
        settle(20);
        expect_pkt("R4 R6", 2, 2, 0, 0);

        // R5 late packet, then an aligned follower proves whole-frame skip
        clear_samples();
        d0c = drop_cnt;
        push_pkt(0, 1, 20, now_time - 32'd5, 3);
        push_pkt(0, 1, 8, 32'hFFFF_FFFF, 4);
        settle(20);
        chk(drop_cnt == d0c + 1, "R5 drop pulse count", 32'(drop_cnt - d0c), 32'd1);
        chk(drop_flag == 1'b1, "R5 drop flag", 32'(drop_flag), 32'd1);
        expect_pkt("R5 follower", 4, 2, 0, 0);

        // R5 wraparound: stamp just below 2^32 with a small now is late
        clear_samples();
        d0c = drop_cnt;
        push_pkt(0, 1, 12, 32'hFFFF_FF00, 5);
        settle(20);
        chk(drop_cnt == d0c + 1 && s_data.size() == 0, "R5 wrap late",
            32'(drop_cnt - d0c), 32'd1);

        // R9 clear both flags
        @(posedge clk); #1 flag_clr = 1'b1;
        @(posedge clk); #1 flag_clr = 1'b0;
        @(negedge clk);
        chk(drop_flag == 1'b0 && urun_flag == 1'b0, "R9 flags cleared",
            32'({drop_flag, urun_flag}), 32'd0);

        // R7 gapless burst of three full-length packets, no underrun
        clear_samples();
        u0c = urun_cnt;
        push_pkt(1, 0, 504, 32'hFFFF_FFFF, 6);
        push_pkt(0, 0, 504, 32'hFFFF_FFFF, 7);
        push_pkt(0, 1, 504, 32'hFFFF_FFFF, 8);
        settle(40);
        begin
            bit ok;
            ok = (s_data.size() == 378);
            for (int i = 0; i < s_data.size() && ok; i++) begin
                if (s_data[i] != pl(6 + i / 126, i % 126)) ok = 0;
                if (i > 0 && s_slot[i] != s_slot[i-1] + 1) ok = 0;
            end
            chk(ok, "R7 burst data contiguous", 32'(s_data.size()), 32'd378);
        end
        chk(urun_cnt == u0c, "R7 no underrun in full burst", 32'(urun_cnt - u0c), 32'd0);

        // R7 burst left open with the queue empty gives underruns
        clear_samples();
        u0c = urun_cnt;
        push_pkt(1, 0, 8, 32'hFFFF_FFFF, 9);
        settle(60);
        chk(urun_cnt > u0c, "R7 underrun inside burst", 32'(urun_cnt - u0c), 32'd1);
        chk(urun_flag == 1'b1, "R7 underrun flag", 32'(urun_flag), 32'd1);
        @(negedge clk);
        chk(dac_data == 0, "R8 zero on empty slot", dac_data, 32'd0);

        // R8 closing packet ends the burst; later empty slots are quiet
        push_pkt(0, 1, 8, 32'hFFFF_FFFF, 10);
        settle(10);
        u0c = urun_cnt;
        repeat (100) @(posedge clk);
        #1;
        chk(urun_cnt == u0c, "R8 no underrun after end of burst", 32'(urun_cnt - u0c), 32'd0);
        @(posedge clk); #1 flag_clr = 1'b1;
        @(posedge clk); #1 flag_clr = 1'b0;
        @(negedge clk);
        chk(urun_flag == 1'b0, "R9 underrun flag cleared", 32'(urun_flag), 32'd0);

        // R7 a dropped end-of-burst packet also closes the burst
        push_pkt(1, 0, 4, 32'hFFFF_FFFF, 11);
        push_pkt(0, 1, 4, now_time - 32'd3, 12);
        settle(10);
        u0c = urun_cnt;
        repeat (100) @(posedge clk);
        #1;
        chk(urun_cnt == u0c, "R7 dropped end closes burst", 32'(urun_cnt - u0c), 32'd0);

        // R6 length sweep 0..40 plus the 504 and 511 limits
        for (int k = 0; k < 43; k++) begin
            len  = (k < 41) ? k : ((k == 41) ? 504 : 511);
            expw = (len / 4 > 126) ? 126 : len / 4;
            clear_samples();
            push_pkt(0, 1, len, 32'hFFFF_FFFF, 20 + k);
            settle(12);
            expect_pkt("R6 length sweep", 20 + k, expw, 0, 0);
        end

        // R2 time base tracked every enable
        chk(time_err == 0 && smp_seen > 0, "R2 time base", 32'(time_err), 32'd0);

        report();
    end

endmodule